// File: doc/BRIEF.md
# Handshaked bidirectional parallel port

This block is one parallel I/O port: a 16-bit word channel between a host register interface and an external device. The host sees two registers. The first is the data register, which holds the output word in a latch. The second is a control/status register, which holds a direction bit and also shows the device's ready line. On the device side the port has a ready output, a ready input from the device, and a data bus that can be driven or left in high impedance. That bus appears at the ports as a pin driver value, a per-bus output enable and a pin sample input.

Software picks the direction with the direction bit. While the bit is clear, the port tells the device it is ready and acts as an input: a read of the data register returns the pins straight through, with no latch. When the bit is set, the port drives the latched word, but only while the device is asserting its ready line. Because reads always sample the pins, a read in output mode shows the word that is actually being driven.

A bus-initialise pulse clears the direction bit. It leaves the output latch and the ready status untouched. The device-ready input is resynchronised before any logic uses it.

Top module: `parPort`

## Requirements
- R1: After reset, the following hold: the direction bit is 0, the output latch is 0, `portReady` is 1 and `pinOe` is 0.
- R2: A write with `wrEn`=1 and `regSel`=0 loads the output latch. Only the bytes whose `byteEn` bit is set are loaded (bit 0 covers [7:0], bit 1 covers [15:8]), and the result is visible on `pinOut` after the same clock edge. No other access changes the latch.
- R3: A write with `regSel`=1 and `byteEn[1]`=1 loads the direction bit from `wrData[8]`. A control write with `byteEn[1]`=0 leaves the direction bit unchanged.
- R4: `portReady` is 1 exactly when the direction bit is 0.
- R5: `pinOe` is 1 only when the direction bit is 1 and the synchronised device-ready is 1. `pinOut` always carries the output latch.
- R6: `devReady` passes through two flops. A change applied before clock edge k is seen in status and in `pinOe` after edge k+1, and not after edge k.
- R7: A read with `rdEn`=1 and `regSel`=1 returns, in the same cycle, bit 15 = synchronised device-ready, bit 8 = direction bit and every other bit 0. When `rdEn` is 0, `rdData` is 0.
- R8: A read with `rdEn`=1 and `regSel`=0 returns `pinIn` in the same cycle, without latching. In output mode the pins carry the latch, so the read returns the latch.
- R9: While `busInit` is 1 at a clock edge, the direction bit is cleared, and this wins over a simultaneous control write. The output latch and the ready status bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busInit | input | 1 | Synchronous bus-initialise pulse |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe, data returned same cycle |
| regSel | input | 1 | 0 selects the data register, 1 selects the control/status register |
| byteEn | input | 2 | Byte write enables |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data |
| devReady | input | 1 | Ready line from the device, asynchronous |
| portReady | output | 1 | Ready line toward the device |
| pinIn | input | 16 | Sampled state of the data pins |
| pinOut | output | 16 | Value for the pin drivers |
| pinOe | output | 1 | Enable for the pin drivers; 0 means high impedance |

## Verification
The assertions assume that the host raises at most one of `wrEn` and `rdEn` in a cycle. They also assume that `devReady` is steady for at least one full clock when sampled. The bench drives every input at the falling edge, so the device-ready changes it applies always meet the synchroniser cleanly. The bench models the pad: `pinIn` follows `pinOut` while `pinOe` is 1, and a bench-chosen device word otherwise. The loopback read of R8 is therefore a real observation of the driven word.

// File: rtl/parPortPkg.sv
package parPortPkg;
  typedef struct packed {
    logic latchWr;
    logic dirWr;
    logic dirClr;
    logic rdPins;
    logic rdCsr;
  } portStrobes_t;
endpackage

// File: rtl/parPortCtrl.sv
module parPortCtrl
  import parPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busInit,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic         regSel,
  input  logic         dirByteEn,
  input  logic         devReady,
  output portStrobes_t strobes,
  output logic         readySync
);
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else if (s == 0) syncChain[s] <= devReady;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign readySync = syncChain[SYNC_STAGES-1];

  always_comb begin
    strobes.latchWr = wrEn && !regSel;
    strobes.dirClr  = busInit;
    strobes.dirWr   = wrEn && regSel && dirByteEn && !busInit;
    strobes.rdPins  = rdEn && !regSel;
    strobes.rdCsr   = rdEn && regSel;
  end
endmodule

// File: rtl/parPortData.sv
module parPortData
  import parPortPkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int DIR_BIT = 8,
  parameter int RDY_BIT = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobes_t         strobes,
  input  logic [WIDTH/8-1:0]   byteEn,
  input  logic [WIDTH-1:0]     wrData,
  input  logic                 readySync,
  input  logic [WIDTH-1:0]     pinIn,
  output logic [WIDTH-1:0]     rdData,
  output logic [WIDTH-1:0]     pinOut,
  output logic                 pinOe,
  output logic                 portReady
);
  localparam int LANES = WIDTH / 8;

  logic [WIDTH-1:0] outLatch;
  logic             dirOut;
  logic [WIDTH-1:0] csrView;

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outLatch[b*8 +: 8] <= '0;
        else if (strobes.latchWr && byteEn[b]) outLatch[b*8 +: 8] <= wrData[b*8 +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirOut <= 1'b0;
    else if (strobes.dirClr) dirOut <= 1'b0;
    else if (strobes.dirWr) dirOut <= wrData[DIR_BIT];
  end

  always_comb begin
    csrView          = '0;
    csrView[DIR_BIT] = dirOut;
    csrView[RDY_BIT] = readySync;
  end

  always_comb begin
    if (strobes.rdCsr) rdData = csrView;
    else if (strobes.rdPins) rdData = pinIn;
    else rdData = '0;
  end

  assign pinOut    = outLatch;
  assign pinOe     = dirOut && readySync;
  assign portReady = !dirOut;
endmodule

// File: rtl/parPort.sv
module parPort
  import parPortPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIR_BIT     = 8,
  parameter int RDY_BIT     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busInit,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic               regSel,
  input  logic [WIDTH/8-1:0] byteEn,
  input  logic [WIDTH-1:0]   wrData,
  output logic [WIDTH-1:0]   rdData,
  input  logic               devReady,
  output logic               portReady,
  input  logic [WIDTH-1:0]   pinIn,
  output logic [WIDTH-1:0]   pinOut,
  output logic               pinOe
);
  localparam int DIR_LANE = DIR_BIT / 8;

  portStrobes_t strobes;
  logic         readySync;

  parPortCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .busInit(busInit), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .dirByteEn(byteEn[DIR_LANE]), .devReady(devReady),
    .strobes(strobes), .readySync(readySync)
  );

  parPortData #(.WIDTH(WIDTH), .DIR_BIT(DIR_BIT), .RDY_BIT(RDY_BIT)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteEn(byteEn), .wrData(wrData),
    .readySync(readySync), .pinIn(pinIn), .rdData(rdData), .pinOut(pinOut),
    .pinOe(pinOe), .portReady(portReady)
  );
endmodule

// File: rtl/parPortChecker.sv
module parPortChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busInit,
  input logic        wrEn,
  input logic        rdEn,
  input logic        regSel,
  input logic [1:0]  byteEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        devReady,
  input logic        portReady,
  input logic [15:0] pinOut,
  input logic        pinOe
);
  p_oe_needs_output_r5: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> !portReady);

  p_oe_follows_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> $past(devReady, 2));

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !regSel) |=> $stable(pinOut));

  p_init_clears_dir_r9: assert property (@(posedge clk) disable iff (!rstN)
    busInit |=> (portReady && !pinOe));

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel && byteEn[1] && !busInit) |=> (portReady == !$past(wrData[8])));

  p_csr_zero_bits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel) |-> (rdData[14:9] == 6'd0 && rdData[7:0] == 8'd0));

  p_idle_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == 16'd0));
endmodule

bind parPort parPortChecker i_checker (
  .clk(clk), .rstN(rstN), .busInit(busInit), .wrEn(wrEn), .rdEn(rdEn),
  .regSel(regSel), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
  .devReady(devReady), .portReady(portReady), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/test_parPort.sv
module test_parPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busInit = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        regSel = 1'b0;
  logic [1:0]  byteEn = 2'b00;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        devReady = 1'b0;
  logic        portReady;
  logic [15:0] pinIn;
  logic [15:0] pinOut;
  logic        pinOe;
  logic [15:0] devDrive = 16'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign pinIn = pinOe ? pinOut : devDrive;

  parPort i_parPort (
    .clk(clk), .rstN(rstN), .busInit(busInit), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .devReady(devReady), .portReady(portReady), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // byteEn, write data, expected latch afterwards
  localparam logic [33:0] VEC [6] = '{
    {2'b11, 16'h1234, 16'h1234},
    {2'b01, 16'h00AB, 16'h12AB},
    {2'b10, 16'hCD00, 16'hCDAB},
    {2'b00, 16'hFFFF, 16'hCDAB},
    {2'b11, 16'hFFFF, 16'hFFFF},
    {2'b10, 16'h0000, 16'h00FF}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic sel, input logic [1:0] be, input logic [15:0] d,
                         input logic init);
    @(negedge clk);
    wrEn = 1'b1; regSel = sel; byteEn = be; wrData = d; busInit = init;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 2'b00; busInit = 1'b0;
  endtask

  task automatic doRead(input logic sel, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; regSel = sel;
    #1 v = rdData;
    rdEn = 1'b0;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 latch", pinOut, 16'h0);
    check("R1 portReady", {15'd0, portReady}, 16'd1);
    check("R1 pinOe", {15'd0, pinOe}, 16'd0);
    doRead(1'b1, v); check("R1 csr", v, 16'h0000);
    check("R7 idle read", rdData, 16'h0);

    for (int i = 0; i < 6; i++) begin
      doWrite(1'b0, VEC[i][33:32], VEC[i][31:16], 1'b0);
      check("R2 byte lanes", pinOut, VEC[i][15:0]);
    end

    devDrive = 16'hA5A5;
    doRead(1'b0, v); check("R8 input read", v, 16'hA5A5);
    devDrive = 16'h5A3C;
    doRead(1'b0, v); check("R8 unlatched", v, 16'h5A3C);

    doWrite(1'b1, 2'b01, 16'hFFFF, 1'b0);
    check("R3 low byte ignored", {15'd0, portReady}, 16'd1);
    doRead(1'b1, v); check("R3 csr unchanged", v, 16'h0000);

    doWrite(1'b1, 2'b10, 16'h0100, 1'b0);
    check("R4 portReady low", {15'd0, portReady}, 16'd0);
    check("R5 no drive without ready", {15'd0, pinOe}, 16'd0);
    doRead(1'b0, v); check("R5 pins undriven", v, 16'h5A3C);

    @(negedge clk);
    devReady = 1'b1;
    @(negedge clk);
    check("R6 one edge not enough", {15'd0, pinOe}, 16'd0);
    doRead(1'b1, v); check("R6 status after two edges", v, 16'h8100);
    check("R5 drive on", {15'd0, pinOe}, 16'd1);
    doRead(1'b0, v); check("R8 loopback", v, 16'h00FF);

    doWrite(1'b1, 2'b11, 16'h0000, 1'b1);
    check("R9 dir cleared", {15'd0, portReady}, 16'd1);
    check("R9 drive off", {15'd0, pinOe}, 16'd0);
    check("R9 latch kept", pinOut, 16'h00FF);
    doRead(1'b1, v); check("R9 ready kept", v, 16'h8000);

    doWrite(1'b1, 2'b10, 16'h0100, 1'b1);
    check("R9 init beats write", {15'd0, portReady}, 16'd1);

    doWrite(1'b1, 2'b10, 16'h0100, 1'b0);
    check("R5 drive again", {15'd0, pinOe}, 16'd1);
    @(negedge clk);
    devReady = 1'b0;
    @(negedge clk);
    check("R6 drop delayed", {15'd0, pinOe}, 16'd1);
    @(negedge clk);
    check("R5 drive off on ready drop", {15'd0, pinOe}, 16'd0);
    doRead(1'b1, v); check("R7 csr dir only", v, 16'h0100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule